// File: doc/BRIEF.md
# Aligned dual-ratio clock divider

This block takes one input clock and derives two slower square waves from it. The first output always runs at half the input rate. The second runs at a quarter or a sixth of the input rate, picked by a select input. Both outputs come from one counter that runs in the input clock domain and advances on input rising edges. Every rising edge the two outputs have in common therefore falls on the same input cycle. A marker output flags each of these shared rising edges, so other logic can find the start of a common period.

A freeze input is sampled on the falling edge of the input clock. It can start or stop the dividers only while the clock is low, so gating never shortens a pulse. An asynchronous master reset drives all outputs low and parks the counter. The next enabled rising edge then starts both outputs together. Holding several instances in reset and releasing them together puts them all in the same phase. A change of ratio waits until the slow output next rises, so no pulse of either ratio is cut short.

Top module: `twin_ratio_divider`

## Requirements
- R1: On every rising input edge while running, `div2_o` inverts, so it runs at half the input rate with 50% duty.
- R2: With `ratio_sel_i` = 0, `divx_o` repeats two high cycles followed by two low cycles.
- R3: With `ratio_sel_i` = 1, `divx_o` repeats three high cycles followed by three low cycles.
- R4: `freeze_i` = 1, as sampled at a falling edge, holds `div2_o` and `divx_o` at the following rising edge, and `align_o` is low after that edge. `freeze_i` = 0 lets them advance.
- R5: `freeze_i` is sampled only on falling input edges. A change made while the clock is low takes effect only after the next falling edge. A change made while the clock is high takes effect at the rising edge right after the falling edge in between.
- R6: While `mrst_i` is high, `div2_o`, `divx_o` and `align_o` are low at once, whatever the clock and `freeze_i` do. The freeze sample is cleared to "stopped".
- R7: After `mrst_i` is released, the first rising edge that follows a falling-edge sample of `freeze_i` = 0 drives `div2_o`, `divx_o` and `align_o` high together.
- R8: `align_o` is high for exactly one input cycle, after each rising edge at which `div2_o` and `divx_o` both go from low to high. Every rise of `divx_o` coincides with a rise of `div2_o`.
- R9: A new `ratio_sel_i` value takes effect only at the edge where `divx_o` next rises. The period in progress completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; outputs advance on its rising edge |
| mrst_i | input | 1 | Asynchronous master reset, active high |
| freeze_i | input | 1 | Hold request, sampled on falling clock edge (1 = hold, 0 = divide) |
| ratio_sel_i | input | 1 | Ratio of the slow output: 0 = divide by 4, 1 = divide by 6 |
| div2_o | output | 1 | Input clock divided by two |
| divx_o | output | 1 | Input clock divided by four or six |
| align_o | output | 1 | One-cycle marker for shared rising edges |

## Verification
The bench changes `freeze_i` both just after a falling edge and just after a rising edge. A design that gated on the rising edge, or sampled the level at the wrong moment, would move one cycle early or late against the reference model. `ratio_sel_i` is switched in the middle of slow periods. A design that applied it at once would give a two- or three-cycle high phase of the wrong length, or a rise of `divx_o` with no rise of `div2_o`. The master reset is asserted in the middle of a cycle, with the freeze input moving, and outputs are checked before the next edge. A design with a synchronous or partial reset would still show a high output there. Long frozen stretches that start just after a marker catch a marker that stays high for more than one cycle.

// File: rtl/twr_pkg.sv
package twr_pkg;

   typedef enum logic {
      RATIO_LO = 1'b0,
      RATIO_HI = 1'b1
   } ratio_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/twr_gate_capture.sv
module twr_gate_capture (
   input  logic clk_i,
   input  logic mrst_i,
   input  logic freeze_i,
   output logic run_o
);

   always_ff @(negedge clk_i or posedge mrst_i) begin
      if (mrst_i) run_o <= 1'b0;
      else        run_o <= ~freeze_i;
   end

endmodule

// File: rtl/twr_phase_counter.sv
module twr_phase_counter
   import twr_pkg::*;
#(
   parameter int DIV_A = 4,
   parameter int DIV_B = 6,
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             mrst_i,
   input  logic             step_i,
   input  logic             sel_i,
   output logic [CNT_W-1:0] nxt_cnt_o,
   output logic [CNT_W-1:0] nxt_half_o
);

   localparam logic [CNT_W-1:0] LAST_A = CNT_W'(DIV_A - 1);
   localparam logic [CNT_W-1:0] LAST_B = CNT_W'(DIV_B - 1);
   localparam logic [CNT_W-1:0] HALF_A = CNT_W'(DIV_A / 2);
   localparam logic [CNT_W-1:0] HALF_B = CNT_W'(DIV_B / 2);

   logic [CNT_W-1:0] cnt_q;
   ratio_e           ratio_q;
   logic [CNT_W-1:0] last_cur;
   logic [CNT_W-1:0] half_cur;
   logic [CNT_W-1:0] half_sel;
   logic             wrap;

   assign last_cur = (ratio_q == RATIO_HI) ? LAST_B : LAST_A;
   assign half_cur = (ratio_q == RATIO_HI) ? HALF_B : HALF_A;
   assign half_sel = sel_i ? HALF_B : HALF_A;
   assign wrap     = (cnt_q >= last_cur);

   assign nxt_cnt_o  = wrap ? '0 : cnt_q + 1'b1;
   assign nxt_half_o = wrap ? half_sel : half_cur;

   // Reset parks the counter on the last step of the long ratio so the
   // first advance wraps, loads the selected ratio and starts both outputs.
   always_ff @(posedge clk_i or posedge mrst_i) begin
      if (mrst_i) begin
         cnt_q   <= LAST_B;
         ratio_q <= RATIO_HI;
      end else if (step_i) begin
         cnt_q <= nxt_cnt_o;
         if (wrap) ratio_q <= ratio_e'(sel_i);
      end
   end

   // R2 R3
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      cnt_q <= last_cur);

   // R9
   ratio_switch_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      !$stable(ratio_q) |-> (cnt_q == '0));

endmodule

// File: rtl/twr_out_stage.sv
module twr_out_stage #(
   parameter int CNT_W = 3
) (
   input  logic             clk_i,
   input  logic             mrst_i,
   input  logic             step_i,
   input  logic [CNT_W-1:0] nxt_cnt_i,
   input  logic [CNT_W-1:0] nxt_half_i,
   output logic             div2_o,
   output logic             divx_o,
   output logic             align_o
);

   always_ff @(posedge clk_i or posedge mrst_i) begin
      if (mrst_i) begin
         div2_o  <= 1'b0;
         divx_o  <= 1'b0;
         align_o <= 1'b0;
      end else if (step_i) begin
         div2_o  <= ~nxt_cnt_i[0];
         divx_o  <= (nxt_cnt_i < nxt_half_i);
         align_o <= (nxt_cnt_i == '0);
      end else begin
         align_o <= 1'b0;
      end
   end

   // R1
   half_toggle_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      step_i |=> (div2_o != $past(div2_o)));

   // R4
   hold_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      !step_i |=> ($stable(div2_o) && $stable(divx_o) && !align_o));

   // R6
   reset_low_chk: assert property (@(posedge clk_i)
      mrst_i |-> (!div2_o && !divx_o && !align_o));

   // R8
   rise_align_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      $rose(divx_o) |-> $rose(div2_o));

   // R8
   marker_high_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      align_o |-> (div2_o && divx_o));

   // R8
   marker_single_chk: assert property (@(posedge clk_i) disable iff (mrst_i)
      align_o |=> !align_o);

endmodule

// File: rtl/twin_ratio_divider.sv
module twin_ratio_divider
   import twr_pkg::*;
#(
   parameter int DIV_A = 4,
   parameter int DIV_B = 6
) (
   input  logic clk_i,
   input  logic mrst_i,
   input  logic freeze_i,
   input  logic ratio_sel_i,
   output logic div2_o,
   output logic divx_o,
   output logic align_o
);

   localparam int MAX_DIV = max_int(DIV_A, DIV_B);
   localparam int CNT_W   = $clog2(MAX_DIV);

   generate
      if (DIV_A < 4 || (DIV_A % 2) != 0) begin : g_bad_div_a
         $error("DIV_A must be even and at least 4");
      end
      if (DIV_B < 4 || (DIV_B % 2) != 0) begin : g_bad_div_b
         $error("DIV_B must be even and at least 4");
      end
   endgenerate

   logic             run;
   logic [CNT_W-1:0] nxt_cnt;
   logic [CNT_W-1:0] nxt_half;

   twr_gate_capture u_gate (
      .clk_i    (clk_i),
      .mrst_i   (mrst_i),
      .freeze_i (freeze_i),
      .run_o    (run)
   );

   twr_phase_counter #(
      .DIV_A (DIV_A),
      .DIV_B (DIV_B),
      .CNT_W (CNT_W)
   ) u_count (
      .clk_i      (clk_i),
      .mrst_i     (mrst_i),
      .step_i     (run),
      .sel_i      (ratio_sel_i),
      .nxt_cnt_o  (nxt_cnt),
      .nxt_half_o (nxt_half)
   );

   twr_out_stage #(
      .CNT_W (CNT_W)
   ) u_out (
      .clk_i      (clk_i),
      .mrst_i     (mrst_i),
      .step_i     (run),
      .nxt_cnt_i  (nxt_cnt),
      .nxt_half_i (nxt_half),
      .div2_o     (div2_o),
      .divx_o     (divx_o),
      .align_o    (align_o)
   );

endmodule

// File: tb/twin_ratio_divider_test.sv
`timescale 1ns/1ps
module twin_ratio_divider_test;

   logic clk = 1'b0;
   logic mrst;
   logic freeze;
   logic sel;
   logic div2, divx, align;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R7";

   always #10 clk = ~clk;

   twin_ratio_divider uut (
      .clk_i       (clk),
      .mrst_i      (mrst),
      .freeze_i    (freeze),
      .ratio_sel_i (sel),
      .div2_o      (div2),
      .divx_o      (divx),
      .align_o     (align)
   );

   // behavioural reference
   int   m_pos;
   int   m_ratio;
   bit   m_run;
   logic e_d2, e_dx, e_mk;

   always @(negedge clk or posedge mrst) begin
      if (mrst) m_run = 1'b0;
      else      m_run = !freeze;
   end

   always @(posedge clk or posedge mrst) begin
      if (mrst) begin
         m_pos = -1; m_ratio = 6;
         e_d2 = 1'b0; e_dx = 1'b0; e_mk = 1'b0;
      end else if (m_run) begin
         if (m_pos < 0 || m_pos == m_ratio - 1) begin
            m_pos = 0;
            m_ratio = sel ? 6 : 4;
         end else begin
            m_pos = m_pos + 1;
         end
         e_d2 = (m_pos % 2 == 0);
         e_dx = (m_pos < m_ratio / 2);
         e_mk = (m_pos == 0);
      end else begin
         e_mk = 1'b0;
      end
   end

   task automatic check3(input string req, input logic a2, input logic ax, input logic am);
      checks++;
      if (div2 !== a2 || divx !== ax || align !== am) begin
         fails++;
         $display("FAIL %s: got div2=%b divx=%b align=%b expected %b %b %b at %0t",
                  req, div2, divx, align, a2, ax, am, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      check3(cur_req, e_d2, e_dx, e_mk);
   end

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #4_000_000;
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      mrst = 1'b1; freeze = 1'b0; sel = 1'b0;
      #5;
      check3("R6", 1'b0, 1'b0, 1'b0);
      #40;                 // t=45, clock low
      mrst = 1'b0;
      cur_req = "R7";
      @(posedge clk); #3;  // t=53, no falling edge sampled yet: still parked
      check3("R7", 1'b0, 1'b0, 1'b0);
      @(posedge clk); #3;  // t=73, first step
      check3("R7", 1'b1, 1'b1, 1'b1);
      cur_req = "R2";
      cycles(20);
      cur_req = "R1";
      cycles(8);
      // R9: switch mid period
      cur_req = "R9";
      @(posedge clk); #5 sel = 1'b1;
      cycles(6);
      cur_req = "R3";
      cycles(30);
      // R9: switch back mid period
      cur_req = "R9";
      @(posedge clk); @(posedge clk); #5 sel = 1'b0;
      cycles(12);
      // R4: hold while clock high request
      cur_req = "R4";
      @(posedge clk); #5 freeze = 1'b1;
      cycles(7);
      @(posedge clk); #5 freeze = 1'b0;
      cycles(5);
      // R5: change right after a falling edge
      cur_req = "R5";
      @(negedge clk); #3 freeze = 1'b1;
      cycles(4);
      @(negedge clk); #3 freeze = 1'b0;
      cycles(3);
      @(negedge clk); #8 freeze = 1'b1;
      cycles(2);
      @(posedge clk); #8 freeze = 1'b0;
      cycles(5);
      // R4 held just after a marker
      cur_req = "R4";
      wait (align === 1'b1);
      @(negedge clk); #2 freeze = 1'b1;
      cycles(5);
      @(negedge clk); #2 freeze = 1'b0;
      cycles(6);
      // R6: asynchronous reset in mid cycle
      cur_req = "R6";
      @(posedge clk); #5 mrst = 1'b1;
      #2 check3("R6", 1'b0, 1'b0, 1'b0);
      freeze = 1'b1; #13 freeze = 1'b0;
      cycles(2);
      #6 check3("R6", 1'b0, 1'b0, 1'b0);
      sel = 1'b1;
      @(negedge clk); #4 mrst = 1'b0;
      cur_req = "R7";
      cycles(14);
      // R8: mixed stimulus
      cur_req = "R8";
      for (int k = 0; k < 400; k++) begin
         @(posedge clk);
         #5;
         if ((k % 7) == 3) sel = ~sel;
         if ((k % 11) == 5) freeze = 1'b1;
         if ((k % 11) == 8) freeze = 1'b0;
         if ((k % 13) == 9) begin #8 freeze = ~freeze; end
      end
      freeze = 1'b0;
      cycles(10);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule